// File: doc/BRIEF.md
# Flash Program and Block-Erase Sequencer

This controller sits between a command decoder and a flash cell array. It takes single-word program requests and block-erase requests and checks whether the target may be altered. It then runs the pulse-and-verify algorithm as a state machine and reports the outcome in an 8-bit status byte that a host can read. The array is split into `NUM_BLOCKS` equally sized blocks of `BLK_WORDS` words. A word address carries the block index in its upper bits and the word offset in its lower bits.

One block is the boot block: block 0 when `BOOT_AT_TOP` is 0, or the highest block when it is 1. The boot block may be altered only while the high-voltage reset flag or the write-protect pin is high. Every block also needs a valid programming voltage.

A program request pulses the cell and reads it back, repeating up to `PGM_MAX` times. An erase first programs every word of the block to zero, with the same retry rule per word. It then applies block-wide erase pulses, each followed by a scan of the block for all-ones, up to `ERS_MAX` times. An erase can be parked with a suspend input and continued with a resume input.

Top module: `flash_pe_seq`

## Requirements
- R1: During and directly after reset the status byte reads 0x80 and no program or erase pulse is driven.
- R2: Status layout: bit 7 ready (1 when idle or suspended), bit 6 erase parked, bit 5 erase failure, bit 4 program failure, bit 3 voltage/protection rejection. Bits 2..0 always read 0.
- R3: An accepted program alternates one pulse cycle (`arr_prog` high, `arr_wdata` = request data) with one read-back cycle. It finishes when the read-back equals the request data, so with n pulses needed, ready returns 2n cycles after the accepting edge.
- R4: If the read-back still differs after `PGM_MAX` pulses, bit 4 is set and the sequencer goes idle 2*`PGM_MAX` cycles after acceptance.
- R5: An erase drives each word of the addressed block to 0x00 (pulse with data 0, then read-back) before its first erase pulse.
- R6: After pre-programming, an erase pulse is followed by a scan that reads each word of the block for all-ones. Only the addressed block changes. A first-pass erase takes 3*`BLK_WORDS`+1 busy cycles.
- R7: A failed scan re-pulses the block and restarts the scan at word 0. After `ERS_MAX` erase pulses without a clean scan, bit 5 is set. With a block that never erases, busy time is 2*`BLK_WORDS`+2*`ERS_MAX` cycles.
- R8: A request with `vpp_ok` low is not run: bit 3 is set on the next edge, ready stays 1 and no pulse occurs.
- R9: A request to the boot block while both `hv_reset` and `wp_pin` are low is not run. It sets bit 3 plus bit 4 (program) or bit 5 (erase) and leaves the array untouched. Non-boot blocks need only `vpp_ok`.
- R10: Bits 5..3 stay set until `clr_status` is high at an edge. An error set on that same edge wins over the clear.
- R11: `suspend` high during an erase parks the sequencer after the current step: status reads 0xC0 and no pulses occur. `resume` continues from the next step, and the erase completes.
- R12: Requests arriving while busy or parked are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 1 | 0 program word, 1 erase block |
| req_addr | input | ADDR_W | Word address (block index in upper bits) |
| req_data | input | DATA_W | Data to program |
| suspend | input | 1 | Park a running erase |
| resume | input | 1 | Continue a parked erase |
| clr_status | input | 1 | Clear error bits 5..3 |
| hv_reset | input | 1 | High-voltage level seen on reset pin |
| wp_pin | input | 1 | Write-protect pin, high unlocks boot block |
| vpp_ok | input | 1 | Programming voltage valid |
| arr_addr | output | ADDR_W | Cell address for pulse or read |
| arr_wdata | output | DATA_W | Data for a program pulse |
| arr_prog | output | 1 | Program pulse (clears bits where data is 0) |
| arr_erase | output | 1 | Erase pulse for the block of `arr_addr` |
| arr_rdata | input | DATA_W | Combinational read of `arr_addr` |
| status | output | 8 | Status byte |

## Verification
Every result is due at a fixed number of edges after the accepting edge. Rejections show in the status byte one edge later. A program releases ready 2 edges per pulse, a clean erase after 49 edges, and a stuck erase after 160 edges (default parameters). The bench drives inputs and samples on falling edges. It counts the falling edges on which ready is low and compares that count with the figure derived from the requirement. Array effects and pulse counts are read from the bench's own cell model once ready has returned, or while the sequencer is parked.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    localparam int STATUS_W   = 8;
    localparam int SB_READY   = 7;
    localparam int SB_PARKED  = 6;
    localparam int SB_ERS_ERR = 5;
    localparam int SB_WR_ERR  = 4;
    localparam int SB_VPP_ERR = 3;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PGM_PULSE,
        S_PGM_VFY,
        S_PRE_PULSE,
        S_PRE_VFY,
        S_ERS_PULSE,
        S_ERS_VFY,
        S_PARKED
    } seq_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef struct packed {
        logic ers;
        logic wr;
        logic vpp;
    } err_flags_t;

    localparam err_flags_t NO_ERR = '0;

    function automatic logic [STATUS_W-1:0] build_status(input logic ready,
                                                         input logic parked,
                                                         input err_flags_t e);
        logic [STATUS_W-1:0] s;
        s             = '0;
        s[SB_READY]   = ready;
        s[SB_PARKED]  = parked;
        s[SB_ERS_ERR] = e.ers;
        s[SB_WR_ERR]  = e.wr;
        s[SB_VPP_ERR] = e.vpp;
        return s;
    endfunction

    function automatic logic in_erase_phase(input seq_state_e s);
        return (s == S_PRE_PULSE) || (s == S_PRE_VFY) ||
               (s == S_ERS_PULSE) || (s == S_ERS_VFY);
    endfunction

endpackage

// File: rtl/fpe_guard.sv
module fpe_guard
    import flash_pe_pkg::*;
#(
    parameter int NUM_BLOCKS  = 11,
    parameter int BLK_IDX_W   = 4,
    parameter bit BOOT_AT_TOP = 1'b0
) (
    input  logic [BLK_IDX_W-1:0] blk_idx,
    input  op_e                  op,
    input  logic                 hv_reset,
    input  logic                 wp_pin,
    input  logic                 vpp_ok,
    output logic                 permit,
    output err_flags_t           rej
);
    localparam int BOOT_IDX = BOOT_AT_TOP ? NUM_BLOCKS - 1 : 0;

    logic is_boot;
    logic locked;

    always_comb begin
        is_boot = (blk_idx == BLK_IDX_W'(BOOT_IDX));
        locked  = is_boot && !(hv_reset || wp_pin);
        permit  = vpp_ok && !locked;
        rej.vpp = !permit;
        rej.wr  = locked && (op == OP_PROGRAM);
        rej.ers = locked && (op == OP_ERASE);
    end
endmodule

// File: rtl/fpe_tries.sv
module fpe_tries #(
    parameter int MAX_TRIES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int CNT_W = $clog2(MAX_TRIES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_W'(MAX_TRIES))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign exhausted = (cnt_q == CNT_W'(MAX_TRIES));
endmodule

// File: rtl/fpe_status.sv
module fpe_status
    import flash_pe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  err_flags_t          set_err,
    input  logic                clr,
    input  logic                ready,
    input  logic                parked,
    output logic [STATUS_W-1:0] status
);
    err_flags_t err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= NO_ERR;
        end else begin
            err_q <= set_err | (clr ? NO_ERR : err_q);
        end
    end

    assign status = build_status(ready, parked, err_q);
endmodule

// File: rtl/fpe_fsm.sv
module fpe_fsm
    import flash_pe_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int OFS_W     = 4,
    parameter int BLK_IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              permit,
    input  err_flags_t        rej,
    input  logic              suspend,
    input  logic              resume,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic              pgm_exh,
    input  logic              ers_exh,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase,
    output logic              pgm_clr,
    output logic              pgm_inc,
    output logic              ers_clr,
    output logic              ers_inc,
    output err_flags_t        err_set,
    output logic              ready,
    output logic              parked
);
    seq_state_e state_q, state_d, ret_q, ret_d, norm_d;
    logic [ADDR_W-1:0]    addr_q, addr_d;
    logic [DATA_W-1:0]    data_q, data_d;
    logic [OFS_W-1:0]     ptr_q, ptr_d;
    logic [BLK_IDX_W-1:0] blk_q;
    logic                 last_word;

    assign blk_q     = addr_q[ADDR_W-1 -: BLK_IDX_W];
    assign last_word = (ptr_q == '1);

    always_comb begin
        norm_d  = state_q;
        ret_d   = ret_q;
        addr_d  = addr_q;
        data_d  = data_q;
        ptr_d   = ptr_q;
        pgm_clr = 1'b0;
        pgm_inc = 1'b0;
        ers_clr = 1'b0;
        ers_inc = 1'b0;
        err_set = NO_ERR;
        case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (permit) begin
                        addr_d  = req_addr;
                        data_d  = req_data;
                        ptr_d   = '0;
                        pgm_clr = 1'b1;
                        ers_clr = 1'b1;
                        norm_d  = (req_op == OP_PROGRAM) ? S_PGM_PULSE : S_PRE_PULSE;
                    end else begin
                        err_set = rej;
                    end
                end
            end
            S_PGM_PULSE: begin
                pgm_inc = 1'b1;
                norm_d  = S_PGM_VFY;
            end
            S_PGM_VFY: begin
                if (arr_rdata == data_q) begin
                    norm_d = S_IDLE;
                end else if (pgm_exh) begin
                    err_set.wr = 1'b1;
                    norm_d     = S_IDLE;
                end else begin
                    norm_d = S_PGM_PULSE;
                end
            end
            S_PRE_PULSE: begin
                pgm_inc = 1'b1;
                norm_d  = S_PRE_VFY;
            end
            S_PRE_VFY: begin
                if (arr_rdata == '0) begin
                    if (last_word) begin
                        ptr_d  = '0;
                        norm_d = S_ERS_PULSE;
                    end else begin
                        ptr_d   = ptr_q + 1'b1;
                        pgm_clr = 1'b1;
                        norm_d  = S_PRE_PULSE;
                    end
                end else if (pgm_exh) begin
                    err_set.ers = 1'b1;
                    norm_d      = S_IDLE;
                end else begin
                    norm_d = S_PRE_PULSE;
                end
            end
            S_ERS_PULSE: begin
                ers_inc = 1'b1;
                ptr_d   = '0;
                norm_d  = S_ERS_VFY;
            end
            S_ERS_VFY: begin
                if (arr_rdata == '1) begin
                    if (last_word) begin
                        norm_d = S_IDLE;
                    end else begin
                        ptr_d = ptr_q + 1'b1;
                    end
                end else if (ers_exh) begin
                    err_set.ers = 1'b1;
                    norm_d      = S_IDLE;
                end else begin
                    norm_d = S_ERS_PULSE;
                end
            end
            S_PARKED: begin
                if (resume) begin
                    norm_d = ret_q;
                end
            end
            default: norm_d = S_IDLE;
        endcase

        state_d = norm_d;
        if (suspend && in_erase_phase(state_q) && (norm_d != S_IDLE)) begin
            state_d = S_PARKED;
            ret_d   = norm_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            ret_q   <= S_IDLE;
            addr_q  <= '0;
            data_q  <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        arr_prog  = (state_q == S_PGM_PULSE) || (state_q == S_PRE_PULSE);
        arr_erase = (state_q == S_ERS_PULSE);
        arr_wdata = (state_q == S_PRE_PULSE) ? '0 : data_q;
        case (state_q)
            S_PRE_PULSE, S_PRE_VFY, S_ERS_VFY: arr_addr = {blk_q, ptr_q};
            S_ERS_PULSE:                       arr_addr = {blk_q, {OFS_W{1'b0}}};
            default:                           arr_addr = addr_q;
        endcase
        ready  = (state_q == S_IDLE) || (state_q == S_PARKED);
        parked = (state_q == S_PARKED);
    end
endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int  NUM_BLOCKS  = 11,
    parameter int  BLK_WORDS   = 16,
    parameter int  DATA_W      = 8,
    parameter int  PGM_MAX     = 16,
    parameter int  ERS_MAX     = 64,
    parameter bit  BOOT_AT_TOP = 1'b0,
    localparam int OFS_W       = $clog2(BLK_WORDS),
    localparam int BLK_IDX_W   = $clog2(NUM_BLOCKS),
    localparam int ADDR_W      = OFS_W + BLK_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              suspend,
    input  logic              resume,
    input  logic              clr_status,
    input  logic              hv_reset,
    input  logic              wp_pin,
    input  logic              vpp_ok,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_prog,
    output logic              arr_erase,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [7:0]        status
);
    op_e        op_in;
    logic       permit;
    err_flags_t rej;
    err_flags_t err_set;
    logic       pgm_clr, pgm_inc, pgm_exh;
    logic       ers_clr, ers_inc, ers_exh;
    logic       ready, parked;

    assign op_in = op_e'(req_op);

    fpe_guard #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLK_IDX_W  (BLK_IDX_W),
        .BOOT_AT_TOP(BOOT_AT_TOP)
    ) u_guard (
        .blk_idx (req_addr[ADDR_W-1 -: BLK_IDX_W]),
        .op      (op_in),
        .hv_reset(hv_reset),
        .wp_pin  (wp_pin),
        .vpp_ok  (vpp_ok),
        .permit  (permit),
        .rej     (rej)
    );

    fpe_tries #(.MAX_TRIES(PGM_MAX)) u_pgm_tries (
        .clk(clk), .rst(rst), .clr(pgm_clr), .inc(pgm_inc), .exhausted(pgm_exh)
    );

    fpe_tries #(.MAX_TRIES(ERS_MAX)) u_ers_tries (
        .clk(clk), .rst(rst), .clr(ers_clr), .inc(ers_inc), .exhausted(ers_exh)
    );

    fpe_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .OFS_W    (OFS_W),
        .BLK_IDX_W(BLK_IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_op   (op_in),
        .req_addr (req_addr),
        .req_data (req_data),
        .permit   (permit),
        .rej      (rej),
        .suspend  (suspend),
        .resume   (resume),
        .arr_rdata(arr_rdata),
        .pgm_exh  (pgm_exh),
        .ers_exh  (ers_exh),
        .arr_addr (arr_addr),
        .arr_wdata(arr_wdata),
        .arr_prog (arr_prog),
        .arr_erase(arr_erase),
        .pgm_clr  (pgm_clr),
        .pgm_inc  (pgm_inc),
        .ers_clr  (ers_clr),
        .ers_inc  (ers_inc),
        .err_set  (err_set),
        .ready    (ready),
        .parked   (parked)
    );

    fpe_status u_status (
        .clk    (clk),
        .rst    (rst),
        .set_err(err_set),
        .clr    (clr_status),
        .ready  (ready),
        .parked (parked),
        .status (status)
    );
endmodule

// File: rtl/fpe_checks.sv
module fpe_checks (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       vpp_ok,
    input logic       clr_status,
    input logic       arr_prog,
    input logic       arr_erase,
    input logic [7:0] status
);
    p_reset_state_r1: assert property (@(posedge clk)
        $fell(rst) |-> (status == 8'h80));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        status[2:0] == 3'b000);

    p_parked_is_ready_r2: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> status[7]);

    p_one_pulse_kind_r6: assert property (@(posedge clk) disable iff (rst)
        !(arr_prog && arr_erase));

    p_ready_no_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        status[7] |-> !(arr_prog || arr_erase));

    p_lowvpp_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (status[7] && !status[6] && req_valid && !vpp_ok) |=> (status[7] && status[3]));

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (($past(status[5:3]) & ~status[5:3]) != 3'b000) |-> $past(clr_status));
endmodule

bind flash_pe_seq fpe_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .vpp_ok    (vpp_ok),
    .clr_status(clr_status),
    .arr_prog  (arr_prog),
    .arr_erase (arr_erase),
    .status    (status)
);

// File: tb/sim_flash_pe_seq.sv
module sim_flash_pe_seq;
    localparam int BW   = 16;
    localparam int PMAX = 16;
    localparam int EMAX = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 0, req_op = 0;
    logic [7:0] req_addr = 0, req_data = 0;
    logic       suspend = 0, resume = 0, clr_status = 0;
    logic       hv_reset = 0, wp_pin = 0, vpp_ok = 1;
    logic [7:0] arr_addr, arr_wdata, arr_rdata, status;
    logic       arr_prog, arr_erase;

    always #2 clk = ~clk;

    flash_pe_seq u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .suspend(suspend),
        .resume(resume), .clr_status(clr_status), .hv_reset(hv_reset),
        .wp_pin(wp_pin), .vpp_ok(vpp_ok), .arr_addr(arr_addr),
        .arr_wdata(arr_wdata), .arr_prog(arr_prog), .arr_erase(arr_erase),
        .arr_rdata(arr_rdata), .status(status)
    );

    // behavioural cell array
    logic [7:0] mem [256];
    int  prog_cnt = 0, ers_cnt = 0, weak_until = 0;
    bit  ers_stuck = 0, first_ers_seen = 0, pre_zero_ok = 0;
    bit  bd_fill = 0, bd_xor = 0, bd_mark = 0;
    logic [7:0] bd_val = 0;
    int  vectors = 0, miscompares = 0;
    bit  done = 0;

    assign arr_rdata = mem[arr_addr];

    function automatic bit blk_all(input logic [3:0] b, input logic [7:0] v);
        for (int j = 0; j < BW; j++) if (mem[{b, 4'(j)}] != v) return 0;
        return 1;
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'h96 ^ 8'(i);
    endfunction

    always @(posedge clk) begin
        if (bd_fill) for (int i = 0; i < 256; i++) mem[i] <= bd_val ^ (bd_xor ? 8'(i) : 8'h00);
        if (bd_mark) first_ers_seen <= 0;
        if (arr_prog) begin
            prog_cnt <= prog_cnt + 1;
            if (prog_cnt >= weak_until) mem[arr_addr] <= mem[arr_addr] & arr_wdata;
        end
        if (arr_erase) begin
            ers_cnt <= ers_cnt + 1;
            if (!first_ers_seen) begin
                first_ers_seen <= 1;
                pre_zero_ok    <= blk_all(arr_addr[7:4], 8'h00);
            end
            if (!ers_stuck)
                for (int j = 0; j < BW; j++) mem[{arr_addr[7:4], 4'(j)}] <= 8'hFF;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] v, input bit x);
        @(negedge clk); bd_fill = 1; bd_val = v; bd_xor = x; bd_mark = 1;
        @(negedge clk); bd_fill = 0; bd_mark = 0;
    endtask

    task automatic issue(input logic op, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); req_valid = 1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk); req_valid = 0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!status[7] && n < 2000) begin n++; @(negedge clk); end
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_status = 1;
        @(negedge clk); clr_status = 0;
    endtask

    function automatic int others_match(input logic [3:0] skip);
        int bad = 0;
        for (int i = 0; i < 176; i++) if (i[7:4] != skip && mem[i] != pat(i)) bad++;
        return bad;
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", "status after reset", status, 8'h80);
        chk("R1", "pulses after reset", {arr_prog, arr_erase}, 0);
    endtask

    task automatic t_program_ok();
        int n;
        fill(8'hFF, 0);
        issue(0, 8'h35, 8'h5A);
        wait_ready(n);
        chk("R3", "single-pulse busy cycles", n, 2);
        chk("R3", "programmed cell", mem[8'h35], 8'h5A);
        chk("R2", "status after good program", status, 8'h80);
    endtask

    task automatic t_program_retry();
        int n;
        weak_until = prog_cnt + 3;
        issue(0, 8'h36, 8'h3C);
        wait_ready(n);
        chk("R3", "busy cycles with 4 pulses", n, 8);
        chk("R3", "cell after retries", mem[8'h36], 8'h3C);
    endtask

    task automatic t_program_fail();
        int n;
        issue(0, 8'h35, 8'hA5);
        wait_ready(n);
        chk("R4", "busy cycles at limit", n, 2 * PMAX);
        chk("R4", "status after program failure", status, 8'h90);
        repeat (3) @(negedge clk);
        chk("R10", "error kept without clear", status, 8'h90);
        pulse_clr();
        chk("R10", "status after clear", status, 8'h80);
    endtask

    task automatic t_vpp_low();
        int p;
        p = prog_cnt;
        vpp_ok = 0;
        issue(0, 8'h47, 8'h00);
        chk("R8", "status after low-voltage program", status, 8'h88);
        chk("R8", "cell untouched", mem[8'h47], 8'hFF);
        chk("R8", "no program pulse", prog_cnt, p);
        vpp_ok = 1;
        pulse_clr();
    endtask

    task automatic t_boot_locked();
        issue(0, 8'h03, 8'h00);
        chk("R9", "status after locked boot program", status, 8'h98);
        chk("R9", "boot cell untouched", mem[8'h03], 8'hFF);
        pulse_clr();
        issue(1, 8'h05, 8'h00);
        chk("R9", "status after locked boot erase", status, 8'hA8);
        pulse_clr();
    endtask

    task automatic t_boot_unlock();
        int n;
        wp_pin = 1;
        issue(0, 8'h03, 8'h11);
        wait_ready(n);
        chk("R9", "boot program with wp high", mem[8'h03], 8'h11);
        chk("R9", "status boot program", status, 8'h80);
        wp_pin = 0; hv_reset = 1;
        issue(1, 8'h0A, 8'h00);
        wait_ready(n);
        chk("R9", "boot erase with hv reset busy", n, 3 * BW + 1);
        chk("R9", "boot block erased", blk_all(4'd0, 8'hFF), 1);
        hv_reset = 0;
    endtask

    task automatic t_erase();
        int n, p;
        fill(8'h96, 1);
        p = prog_cnt;
        issue(1, 8'h5C, 8'h00);
        wait_ready(n);
        chk("R6", "clean erase busy cycles", n, 3 * BW + 1);
        chk("R6", "target block all ones", blk_all(4'd5, 8'hFF), 1);
        chk("R6", "other blocks unchanged (bad words)", others_match(4'd5), 0);
        chk("R5", "block zero before erase pulse", pre_zero_ok, 1);
        chk("R5", "pre-program pulse count", prog_cnt - p, BW);
        issue(1, 8'hA0, 8'h00);
        wait_ready(n);
        chk("R9", "top block free without unlock", status, 8'h80);
        chk("R9", "top block erased", blk_all(4'd10, 8'hFF), 1);
    endtask

    task automatic t_erase_fail();
        int n;
        fill(8'h96, 1);
        ers_stuck = 1;
        issue(1, 8'h23, 8'h00);
        wait_ready(n);
        chk("R7", "stuck erase busy cycles", n, 2 * BW + 2 * EMAX);
        chk("R7", "status after erase failure", status, 8'hA0);
        ers_stuck = 0;
        pulse_clr();
    endtask

    task automatic t_suspend();
        int n, p, e;
        fill(8'h96, 1);
        issue(1, 8'h70, 8'h00);
        repeat (9) @(negedge clk);
        suspend = 1;
        @(negedge clk); suspend = 0;
        chk("R11", "status when parked", status, 8'hC0);
        p = prog_cnt; e = ers_cnt;
        issue(0, 8'h10, 8'h00);
        repeat (3) @(negedge clk);
        chk("R12", "request while parked ignored", mem[8'h10], pat(8'h10));
        chk("R11", "no pulses while parked", (prog_cnt - p) + (ers_cnt - e), 0);
        chk("R11", "still parked", status, 8'hC0);
        resume = 1;
        @(negedge clk); resume = 0;
        wait_ready(n);
        chk("R11", "erase completes after resume", blk_all(4'd7, 8'hFF), 1);
        chk("R11", "status after resumed erase", status, 8'h80);
    endtask

    task automatic t_busy_ignore();
        int n;
        fill(8'hFF, 0);
        weak_until = prog_cnt + 5;
        issue(0, 8'h60, 8'h3C);
        @(negedge clk); req_valid = 1; req_op = 0; req_addr = 8'h61; req_data = 8'h00;
        @(negedge clk); req_valid = 0;
        wait_ready(n);
        chk("R12", "second request ignored while busy", mem[8'h61], 8'hFF);
        chk("R3", "first request completed", mem[8'h60], 8'h3C);
    endtask

    task automatic t_clear_race();
        vpp_ok = 0;
        @(negedge clk); req_valid = 1; req_op = 0; req_addr = 8'h40; clr_status = 1;
        @(negedge clk); req_valid = 0; clr_status = 0;
        chk("R10", "set wins over clear", status, 8'h88);
        vpp_ok = 1;
        pulse_clr();
        chk("R10", "clear alone", status, 8'h80);
    endtask

    initial begin
        t_reset();
        t_program_ok();
        t_program_retry();
        t_program_fail();
        t_vpp_low();
        t_boot_locked();
        t_boot_unlock();
        t_erase();
        t_erase_fail();
        t_suspend();
        t_busy_ignore();
        t_clear_race();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule